// File: doc/BRIEF.md
# Speculative Instruction Cache Line Fill Buffer

This block controls one fill buffer of an instruction cache. The core presents a lookup together with a flag that says whether the lookup follows a branch. The tag and data arrays are read in the lookup cycle, and their hit or miss verdict reaches this block one cycle later. A lookup that follows a branch does not wait for that verdict. The bus request for the first word of the line goes out in the lookup cycle itself, which removes one cycle of miss latency. The cost is an occasional bus transfer whose data is thrown away.

When the verdict is a hit, a sticky flag limits the fill to the word that was already requested. The buffer finishes as soon as that word's response arrives, and the write toward the tag and data arrays is held back. When the verdict is a miss, the buffer fetches every word of the line in ascending order over a pipelined request/grant/response-valid bus. It collects the responses in request order and then raises a one-cycle write request that carries the assembled line. A lookup that does not follow a branch makes no bus request until the miss is known.

Top module: `spec_fill_buf`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy_o`, `hit_o`, `done_o`, `mem_req_o` and `ram_wr_req_o` are low.
- R2: A lookup with `branch_i` high on an idle buffer (`busy_o` low) drives `mem_req_o` high in that same cycle. `mem_addr_o` then equals `lookup_addr_i` with bits [3:0] cleared, which is word 0 of the 16-byte line.
- R3: A lookup with `branch_i` low leaves `mem_req_o` low in the lookup cycle. If `tag_hit_i` is low in the next cycle, word 0 of the line is requested in that next cycle.
- R4: A lookup on an idle buffer allocates it, and `busy_o` is high from the next cycle. A lookup while `busy_o` is high is ignored: it makes no request of its own and does not change the line being filled.
- R5: `tag_hit_i` is sampled only in the cycle after an allocating lookup. A high value there sets `hit_o` from the following cycle, and `hit_o` stays high until the buffer releases. Values of `tag_hit_i` in other cycles have no effect.
- R6: On a hit, at most one word is granted: exactly one after a branch lookup and none otherwise. `done_o` rises in the cycle after that word's response, or two cycles after the lookup when nothing was requested.
- R7: On a hit, `ram_wr_req_o` is never raised for that fill.
- R8: On a miss, exactly 4 words are granted, at addresses base, base+4, base+8 and base+12 in that order. Requests do not wait for responses, so all 4 can be granted before the first response arrives.
- R9: On a miss, `ram_wr_req_o` and `done_o` are both high in the cycle after the 4th response. `ram_wr_addr_o` then equals `lookup_addr_i[31:4]`, and `ram_wr_data_o[32k+31:32k]` holds the response to word k.
- R10: Responses are matched to words in the order the words were granted. A response-valid pulse with no granted request outstanding is ignored.
- R11: In the cycle after `done_o` is high, `busy_o`, `hit_o`, `done_o` and `ram_wr_req_o` are low, and a new lookup can be accepted from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lookup_i | input | 1 | Lookup strobe from the fetch stage |
| branch_i | input | 1 | The lookup follows a branch |
| lookup_addr_i | input | ADDR_W | Byte address of the lookup |
| tag_hit_i | input | 1 | Tag verdict, valid in the cycle after the lookup |
| mem_req_o | output | 1 | Bus request |
| mem_gnt_i | input | 1 | Bus has accepted the request |
| mem_addr_o | output | ADDR_W | Word-aligned request address |
| mem_rvalid_i | input | 1 | Response data valid |
| mem_rdata_i | input | DATA_W | Response data |
| ram_wr_req_o | output | 1 | Write the collected line into the tag and data arrays |
| ram_wr_addr_o | output | LINE_W | Line address for the write |
| ram_wr_data_o | output | WORDS*DATA_W | Collected line, word 0 in the low bits |
| busy_o | output | 1 | Buffer allocated |
| hit_o | output | 1 | Sticky hit flag of the current fill |
| done_o | output | 1 | Fill complete, one-cycle pulse |

## Verification
The bench builds the block with its defaults: 32-bit addresses and data and 4 words per line. With these values the word index fits in bits [3:2], and a full miss needs 4 grants, which is enough to show the whole ascending request train. The bus model varies how often it grants and how long responses take. A long response latency with a grant in every cycle lets all 4 requests go out ahead of the first response. An early stray response-valid pulse during a fill tests that responses are matched to words in order.

// File: rtl/fill_pkg.sv
package fill_pkg;

  // Outcome of the tag check belonging to the current allocation
  typedef enum logic [1:0] {
    TAG_WAIT = 2'd0,
    TAG_HIT  = 2'd1,
    TAG_MISS = 2'd2
  } tag_res_e;

  // Bits needed to count from 0 up to and including n
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fb_track.sv
// Allocation, tag verdict and completion flags of the fill buffer
module fb_track
  import fill_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc,
  input  logic             branch_i,
  input  logic             tag_hit_i,
  input  logic [CNT_W-1:0] req_next,
  input  logic [CNT_W-1:0] rsp_next,
  output logic             busy,
  output logic             done,
  output logic             hit,
  output logic             ram_wr,
  output logic             hit_now,
  output logic [CNT_W-1:0] fill_lim
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORDS);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] NONE = '0;

  tag_res_e res_q;
  logic     busy_q, spec_q, chk_q, done_q, wr_q;
  logic     miss_now, known, done_set;

  // The verdict counts in the cycle it arrives, so a miss starts the
  // refill without waiting for it to be registered
  always_comb begin
    hit_now  = (res_q == TAG_HIT)  | (chk_q & tag_hit_i);
    miss_now = (res_q == TAG_MISS) | (chk_q & ~tag_hit_i);
    known    = hit_now | miss_now;
    if (hit_now)       fill_lim = spec_q ? ONE : NONE;
    else if (miss_now) fill_lim = FULL;
    else               fill_lim = spec_q ? ONE : NONE;
    done_set = busy_q & ~done_q & known &
               (req_next == fill_lim) & (rsp_next == fill_lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      spec_q <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      res_q  <= TAG_WAIT;
    end else if (done_q) begin
      busy_q <= 1'b0;
      spec_q <= 1'b0;
      chk_q  <= 1'b0;
      done_q <= 1'b0;
      wr_q   <= 1'b0;
      res_q  <= TAG_WAIT;
    end else begin
      chk_q <= alloc;
      if (alloc) begin
        busy_q <= 1'b1;
        spec_q <= branch_i;
        res_q  <= TAG_WAIT;
      end else if (chk_q) begin
        res_q <= tag_hit_i ? TAG_HIT : TAG_MISS;
      end
      done_q <= done_set;
      wr_q   <= done_set & ~hit_now;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign hit    = (res_q == TAG_HIT);
  assign ram_wr = wr_q;

endmodule

// File: rtl/fb_issue.sv
// Bus request side: speculative first word, ascending refill, grant count
module fb_issue #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 2,
  parameter int LINE_W = 28,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic              branch_i,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  input  logic              busy,
  input  logic              done,
  input  logic [CNT_W-1:0]  fill_lim,
  input  logic              mem_gnt_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [CNT_W-1:0]  req_cnt,
  output logic [CNT_W-1:0]  req_next,
  output logic [LINE_W-1:0] line_q
);

  localparam int LOW_W = OFF_W + IDX_W;

  logic [LINE_W-1:0] look_line;
  logic              spec_go, want, fire;
  logic              unused_low;

  assign look_line  = lookup_addr_i[ADDR_W-1:LOW_W];
  assign unused_low = ^lookup_addr_i[LOW_W-1:0];

  // The alloc-cycle request comes straight from the lookup inputs;
  // registering it would give back the cycle the speculation saves
  assign spec_go   = alloc & branch_i;
  assign want      = busy & ~done & (req_cnt < fill_lim);
  assign mem_req_o = spec_go | want;
  assign fire      = mem_req_o & mem_gnt_i;

  always_comb begin
    if (alloc) mem_addr_o = {look_line, {LOW_W{1'b0}}};
    else       mem_addr_o = {line_q, req_cnt[IDX_W-1:0], {OFF_W{1'b0}}};
  end

  assign req_next = alloc ? CNT_W'(fire) : req_cnt + CNT_W'(fire);

  always_ff @(posedge clk) begin
    if (rst || done) req_cnt <= '0;
    else             req_cnt <= req_next;
  end

  always_ff @(posedge clk) begin
    if (rst)        line_q <= '0;
    else if (alloc) line_q <= look_line;
  end

endmodule

// File: rtl/fb_collect.sv
// Response side: in-order matching of responses to words, line storage
module fb_collect #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy,
  input  logic                    done,
  input  logic                    hit_now,
  input  logic [CNT_W-1:0]        req_cnt,
  input  logic                    mem_rvalid_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic [CNT_W-1:0]        rsp_next,
  output logic [WORDS*DATA_W-1:0] line_data
);

  logic [CNT_W-1:0] rsp_cnt;
  logic             accept, store;

  // Only responses to granted requests count; anything else is dropped
  assign accept   = mem_rvalid_i & busy & (rsp_cnt < req_cnt);
  assign store    = accept & ~hit_now;
  assign rsp_next = rsp_cnt + CNT_W'(accept);

  always_ff @(posedge clk) begin
    if (rst || done) rsp_cnt <= '0;
    else             rsp_cnt <= rsp_next;
  end

  // Data words carry no reset so they can map onto plain storage
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (store && (rsp_cnt[IDX_W-1:0] == IDX_W'(w))) word_q <= mem_rdata_i;
    end
    assign line_data[w*DATA_W +: DATA_W] = word_q;
  end

endmodule

// File: rtl/spec_fill_buf.sv
module spec_fill_buf
  import fill_pkg::*;
#(
  parameter int  ADDR_W = 32,
  parameter int  DATA_W = 32,
  parameter int  WORDS  = 4,
  localparam int OFF_W  = $clog2(DATA_W / 8),
  localparam int IDX_W  = $clog2(WORDS),
  localparam int LINE_W = ADDR_W - OFF_W - IDX_W,
  localparam int CNT_W  = count_bits(WORDS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lookup_i,
  input  logic                    branch_i,
  input  logic [ADDR_W-1:0]       lookup_addr_i,
  input  logic                    tag_hit_i,
  output logic                    mem_req_o,
  input  logic                    mem_gnt_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  input  logic                    mem_rvalid_i,
  input  logic [DATA_W-1:0]       mem_rdata_i,
  output logic                    ram_wr_req_o,
  output logic [LINE_W-1:0]       ram_wr_addr_o,
  output logic [WORDS*DATA_W-1:0] ram_wr_data_o,
  output logic                    busy_o,
  output logic                    hit_o,
  output logic                    done_o
);

  logic             busy, done, hit_now, alloc;
  logic [CNT_W-1:0] fill_lim, req_cnt, req_next, rsp_next;

  assign alloc = lookup_i & ~busy;

  fb_track #(
    .WORDS (WORDS),
    .CNT_W (CNT_W)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .alloc     (alloc),
    .branch_i  (branch_i),
    .tag_hit_i (tag_hit_i),
    .req_next  (req_next),
    .rsp_next  (rsp_next),
    .busy      (busy),
    .done      (done),
    .hit       (hit_o),
    .ram_wr    (ram_wr_req_o),
    .hit_now   (hit_now),
    .fill_lim  (fill_lim)
  );

  fb_issue #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W),
    .CNT_W  (CNT_W)
  ) u_issue (
    .clk           (clk),
    .rst           (rst),
    .alloc         (alloc),
    .branch_i      (branch_i),
    .lookup_addr_i (lookup_addr_i),
    .busy          (busy),
    .done          (done),
    .fill_lim      (fill_lim),
    .mem_gnt_i     (mem_gnt_i),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .req_cnt       (req_cnt),
    .req_next      (req_next),
    .line_q        (ram_wr_addr_o)
  );

  fb_collect #(
    .DATA_W (DATA_W),
    .WORDS  (WORDS),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_collect (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .hit_now      (hit_now),
    .req_cnt      (req_cnt),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .rsp_next     (rsp_next),
    .line_data    (ram_wr_data_o)
  );

  assign busy_o = busy;
  assign done_o = done;

endmodule

// File: rtl/fill_buf_chk.sv
module fill_buf_chk #(
  parameter int WORDS = 4
) (
  input logic clk,
  input logic rst,
  input logic lookup_i,
  input logic branch_i,
  input logic mem_req_o,
  input logic mem_gnt_i,
  input logic ram_wr_req_o,
  input logic busy_o,
  input logic hit_o,
  input logic done_o
);

  localparam int GW = $clog2(WORDS + 1) + 1;

  // Grants since the latest allocation, counted from the ports
  logic [GW-1:0] gcnt;
  always_ff @(posedge clk) begin
    if (rst)                          gcnt <= '0;
    else if (lookup_i && !busy_o)     gcnt <= (mem_req_o && mem_gnt_i) ? GW'(1) : '0;
    else if (mem_req_o && mem_gnt_i)  gcnt <= gcnt + GW'(1);
  end

  // R2
  branch_req_chk: assert property (@(posedge clk) disable iff (rst)
    (lookup_i && branch_i && !busy_o) |-> mem_req_o);

  // R3
  plain_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (lookup_i && !branch_i && !busy_o) |-> !mem_req_o);

  // R4
  alloc_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (lookup_i && !busy_o) |=> busy_o);

  // R5
  hit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !done_o) |=> hit_o);

  // R6
  hit_one_word_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o && gcnt != '0) |-> !mem_req_o);

  // R7
  hit_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    ram_wr_req_o |-> !hit_o);

  // R8
  grant_limit_chk: assert property (@(posedge clk) disable iff (rst)
    gcnt <= GW'(WORDS));

  // R9
  write_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    ram_wr_req_o |-> done_o);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (!busy_o && !done_o && !hit_o && !ram_wr_req_o));

endmodule

bind spec_fill_buf fill_buf_chk #(.WORDS(WORDS)) u_fill_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_i     (lookup_i),
  .branch_i     (branch_i),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .ram_wr_req_o (ram_wr_req_o),
  .busy_o       (busy_o),
  .hit_o        (hit_o),
  .done_o       (done_o)
);

// File: tb/spec_fill_buf_test.sv
module spec_fill_buf_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int LINE_W = ADDR_W - 4;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    lookup_i = 1'b0;
  logic                    branch_i = 1'b0;
  logic [ADDR_W-1:0]       lookup_addr_i = '0;
  logic                    tag_hit_i = 1'b0;
  logic                    mem_req_o;
  logic                    mem_gnt_i = 1'b0;
  logic [ADDR_W-1:0]       mem_addr_o;
  logic                    mem_rvalid_i = 1'b0;
  logic [DATA_W-1:0]       mem_rdata_i = '0;
  logic                    ram_wr_req_o;
  logic [LINE_W-1:0]       ram_wr_addr_o;
  logic [WORDS*DATA_W-1:0] ram_wr_data_o;
  logic                    busy_o, hit_o, done_o;

  spec_fill_buf uut (
    .clk(clk), .rst(rst), .lookup_i(lookup_i), .branch_i(branch_i),
    .lookup_addr_i(lookup_addr_i), .tag_hit_i(tag_hit_i),
    .mem_req_o(mem_req_o), .mem_gnt_i(mem_gnt_i), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .ram_wr_req_o(ram_wr_req_o), .ram_wr_addr_o(ram_wr_addr_o),
    .ram_wr_data_o(ram_wr_data_o), .busy_o(busy_o), .hit_o(hit_o), .done_o(done_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  // bus model knobs
  int gnt_pct = 100;
  int rv_pct  = 100;
  int lat     = 1;
  bit stray   = 1'b0;
  bit stray_on = 1'b0;

  // monitor results
  int g_cnt = 0, r_cnt = 0, wr_cnt = 0, first_g = -1, last_rsp = -1;
  logic [ADDR_W-1:0] g_addr [8];

  function automatic logic [DATA_W-1:0] memdata(input logic [ADDR_W-1:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int exp_grants(input logic br, input logic hit);
    if (hit) return br ? 1 : 0;
    return WORDS;
  endfunction

  task automatic check_eq(input string tag, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bus model: pipelined, in-order responses, latency counted from grant
  logic [ADDR_W-1:0] fa [16];
  int                ft [16];
  int                fn = 0;
  initial begin
    forever begin
      @(negedge clk);
      #1;
      stray_on = 1'b0;
      if (fn > 0 && cyc >= ft[0] + lat && int'($urandom % 100) < rv_pct) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = memdata(fa[0]);
        for (int i = 0; i < 15; i++) begin
          fa[i] = fa[i+1];
          ft[i] = ft[i+1];
        end
        fn--;
      end else if (stray && fn == 0 && busy_o) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = 32'hDEAD_BEEF;
        stray        = 1'b0;
        stray_on     = 1'b1;
      end else begin
        mem_rvalid_i = 1'b0;
      end
      mem_gnt_i = (int'($urandom % 100) < gnt_pct);
      if (mem_req_o && mem_gnt_i && fn < 16) begin
        fa[fn] = mem_addr_o;
        ft[fn] = cyc;
        fn++;
      end
    end
  end

  // Port monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mem_rvalid_i && !stray_on) begin
        if (first_g < 0) first_g = g_cnt;
        r_cnt++;
        last_rsp = cyc;
      end
      if (mem_req_o && mem_gnt_i) begin
        if (g_cnt < 8) g_addr[g_cnt] = mem_addr_o;
        g_cnt++;
      end
      if (ram_wr_req_o) wr_cnt++;
    end
  end

  task automatic run_fill(input logic [ADDR_W-1:0] addr, input logic br,
                          input logic hit, input bit busy_look, input bit inject);
    logic [ADDR_W-1:0]       base;
    logic [WORDS*DATA_W-1:0] exp_line;
    int lc, ng;
    bit seen;
    base = {addr[ADDR_W-1:4], 4'h0};
    @(negedge clk);
    g_cnt = 0; r_cnt = 0; wr_cnt = 0; first_g = -1; last_rsp = -1;
    stray = inject;
    lookup_i = 1'b1; branch_i = br; lookup_addr_i = addr;
    tag_hit_i = 1'($urandom);
    lc = cyc;
    #3;
    if (br) begin
      check_eq("R2", "request in lookup cycle", 128'(mem_req_o), 128'(1'b1));
      check_eq("R2", "first word address", 128'(mem_addr_o), 128'(base));
    end else begin
      check_eq("R3", "no request in lookup cycle", 128'(mem_req_o), 128'(1'b0));
    end
    @(negedge clk);
    lookup_i = 1'b0; branch_i = 1'($urandom); lookup_addr_i = $urandom;
    tag_hit_i = hit;
    #3;
    check_eq("R4", "busy after lookup", 128'(busy_o), 128'(1'b1));
    if (!br) begin
      check_eq("R3", "request after verdict", 128'(mem_req_o), 128'(!hit));
      if (!hit) check_eq("R3", "word 0 address", 128'(mem_addr_o), 128'(base));
    end
    @(negedge clk);
    tag_hit_i = 1'($urandom);
    if (busy_look) begin
      lookup_i = 1'b1; branch_i = 1'b1; lookup_addr_i = addr ^ 32'h0001_0040;
    end
    #3;
    check_eq("R5", "hit flag", 128'(hit_o), 128'(hit));
    seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done_o) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
      lookup_i = 1'b0;
      tag_hit_i = 1'($urandom);
      #3;
    end
    ng = exp_grants(br, hit);
    if (!seen) begin
      check_eq(hit ? "R6" : "R9", "done never seen", 128'(0), 128'(1));
    end else if (hit) begin
      check_eq("R6", "grants on hit", 128'(g_cnt), 128'(ng));
      check_eq("R10", "responses on hit", 128'(r_cnt), 128'(ng));
      check_eq("R7", "write pulses on hit", 128'(wr_cnt), 128'(0));
      if (br) check_eq("R6", "done cycle", 128'(cyc), 128'(last_rsp + 1));
      else    check_eq("R6", "done cycle", 128'(cyc), 128'(lc + 2));
    end else begin
      check_eq("R8", "grants on miss", 128'(g_cnt), 128'(ng));
      for (int k = 0; k < WORDS; k++)
        check_eq("R8", "ascending address", 128'(g_addr[k]), 128'(base + ADDR_W'(4 * k)));
      check_eq("R10", "responses on miss", 128'(r_cnt), 128'(ng));
      check_eq("R9", "write with done", 128'(ram_wr_req_o), 128'(1'b1));
      check_eq("R9", "done cycle", 128'(cyc), 128'(last_rsp + 1));
      check_eq("R9", "write line address", 128'(ram_wr_addr_o), 128'(addr[ADDR_W-1:4]));
      for (int k = 0; k < WORDS; k++)
        exp_line[k*DATA_W +: DATA_W] = memdata(base + ADDR_W'(4 * k));
      check_eq("R10", "line data order", 128'(ram_wr_data_o), 128'(exp_line));
    end
    @(negedge clk);
    lookup_i = 1'b0;
    #3;
    check_eq("R11", "busy released", 128'(busy_o), 128'(1'b0));
    check_eq("R11", "hit released", 128'(hit_o), 128'(1'b0));
    check_eq("R11", "done pulse ends", 128'(done_o), 128'(1'b0));
    check_eq("R11", "write pulse ends", 128'(ram_wr_req_o), 128'(1'b0));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog: actual still running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #3;
    check_eq("R1", "busy in reset", 128'(busy_o), 128'(1'b0));
    check_eq("R1", "request in reset", 128'(mem_req_o), 128'(1'b0));
    @(negedge clk);
    rst = 1'b0;
    #3;
    check_eq("R1", "busy after reset", 128'(busy_o), 128'(1'b0));
    check_eq("R1", "hit after reset", 128'(hit_o), 128'(1'b0));
    check_eq("R1", "done after reset", 128'(done_o), 128'(1'b0));
    check_eq("R1", "write after reset", 128'(ram_wr_req_o), 128'(1'b0));
    check_eq("R1", "request after reset", 128'(mem_req_o), 128'(1'b0));

    // directed corners
    gnt_pct = 100; rv_pct = 100; lat = 2;
    run_fill(32'h0000_1238, 1'b1, 1'b1, 1'b0, 1'b0);   // branch, hit
    run_fill(32'h0000_2004, 1'b0, 1'b1, 1'b0, 1'b0);   // plain, hit
    run_fill(32'h0000_300C, 1'b1, 1'b0, 1'b0, 1'b0);   // branch, miss
    run_fill(32'h0000_4000, 1'b0, 1'b0, 1'b0, 1'b1);   // plain miss, stray R10
    run_fill(32'h0000_5008, 1'b1, 1'b0, 1'b1, 1'b0);   // R4 lookup while busy
    lat = 6;
    run_fill(32'h0000_6010, 1'b1, 1'b0, 1'b0, 1'b0);
    check_eq("R8", "grants before first response", 128'(first_g), 128'(WORDS));
    gnt_pct = 30; lat = 3;
    run_fill(32'h0000_7020, 1'b1, 1'b1, 1'b0, 1'b0);   // slow grant, hit

    // constrained random fills
    for (int n = 0; n < 48; n++) begin
      gnt_pct = 40 + int'($urandom % 61);
      rv_pct  = 50 + int'($urandom % 51);
      lat     = 1 + int'($urandom % 3);
      run_fill($urandom, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule